// File: doc/BRIEF.md
# Serial Disk Byte Transfer Controller

This block connects a CPU register bus to a disk drive that has no intelligence of its own and delivers its data as one serial bit stream. Outbound bytes are written into a holding register. A parallel-load shift register picks up each byte and sends it out least significant bit first, one bit per bit-clock enable. Inbound bits go into a serial-in shift register. At every byte boundary that register is copied into a read-data register.

A single byte-boundary flag marks every 8th bit in both directions. The flag can raise an interrupt. Software clears it by accessing the data or status registers. A CRC-16 runs alongside the transfer; its reflected polynomial is 0x8408 and its initial value is zero. Software resets the CRC by clearing its enable bit. Another control bit makes the serial output carry the accumulated CRC in place of data bytes. A control register selects the motor state, the transfer direction and the mirroring output. Two status registers report the transfer state and the drive lines.

Register offsets on `reg_addr_i`:

- 0: master enable (bit 0 is disk enable).
- 1: write data.
- 2: control.
- 3: transfer status.
- 4: read data.
- 5: drive status.

Writes to offsets 3, 4 and 5 are ignored. `reg_rdata_o` shows the register at `reg_addr_i` at all times. A read access is marked by `reg_rd_i`, and only a read access has side effects.

Top module: `disk_xfer_ctrl`

## Requirements
- R1: After reset the outputs and registers are as follows:
  - control bit 0 = 0 and bit 1 = 1, so `motor_stop_o` = 1.
  - `mode_read_o`, `mirror_h_o` and `irq_o` are 0.
  - the master disk enable is 0.
  - the byte flag (transfer status bit 1) is 0.
- R2: Control register fields:
  - bit 1 drives `motor_stop_o`.
  - bit 2 drives `mode_read_o` (1 = read, 0 = write).
  - bit 3 drives `mirror_h_o` (1 = horizontal).
- R3: Bit counting runs only when control bit 0 = 1 and bit 1 = 0. While it runs in write mode with control bit 4 = 0, each bit enable presents one bit of the output shift register on `ser_wr_o`, least significant bit first.
  - While counting is held, the output register follows the write-data register.
  - At each byte boundary the output register loads the current write-data value.
- R4: In read mode, `ser_rd_i` is sampled on each running bit enable, least significant bit first. After the 8th bit, the read-data register (offset 4) holds the assembled byte.
- R5: The byte flag (status bit 1) is set on every 8th running bit enable. The following accesses clear it:
  - a write to offset 1.
  - a read access of offset 4.
  - a read access of offset 3.

  A control write leaves the flag unchanged.
- R6: While control bit 0 = 0 or control bit 1 = 1, bit enables have no effect: the flag does not rise, and the bit count returns to zero.
- R7: When control bit 7 = 1 and master bit 0 = 1, `irq_o` rises together with the byte flag. The following accesses clear it:
  - a control write.
  - a write to offset 1.
  - a read access of offset 4.
  - a read access of offset 3.

  With control bit 7 = 0 the flag still rises, but `irq_o` stays 0.
- R8: Writing master bit 0 = 0 clears a pending `irq_o` at once. While master bit 0 is 0, `irq_o` stays 0 at later byte boundaries.
- R9: With control bit 6 = 1, the CRC updates on each running bit. Its input bit is `ser_rd_i` in read mode and the transmitted bit in write mode. Status bit 4 = 1 when the CRC residue is non-zero.
  - After data followed by its correct CRC (low byte first, least significant bit first), bit 4 reads 0.
  - Writing control bit 6 = 0 resets the CRC to zero.
- R10: In write mode with control bit 4 = 1, `ser_wr_o` shifts out the accumulated CRC, least significant bit first.
- R11: Drive and transfer status bits:
  - transfer status bit 6 = `drv_eoh_i`.
  - transfer status bit 7 = 1 when the disk is inserted and ready.
  - drive status bit 0 = `drv_absent_i`, bit 1 = `drv_not_ready_i`, bit 2 = `drv_protect_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read access strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of addressed register |
| bit_en_i | input | 1 | Bit-rate clock enable |
| ser_rd_i | input | 1 | Serial data from drive |
| drv_absent_i | input | 1 | Disk not inserted |
| drv_not_ready_i | input | 1 | Drive not ready |
| drv_protect_i | input | 1 | Write protected or ejected |
| drv_eoh_i | input | 1 | Head at end of track |
| ser_wr_o | output | 1 | Serial data to drive |
| motor_stop_o | output | 1 | Motor stop request |
| mode_read_o | output | 1 | Transfer direction, 1 = read |
| mirror_h_o | output | 1 | Mirroring select, 1 = horizontal |
| irq_o | output | 1 | Disk interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and a 16-bit CRC with polynomial 0x8408. With these values a whole byte takes eight bit enables, so every flag clear path and interrupt acknowledge path can be reached within a few bytes. A complete data-plus-CRC frame takes only four bytes, which puts both the zero-residue case and the corrupted-residue case within reach.

// File: rtl/disk_xfer_pkg.sv
package disk_xfer_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_MASTER = 3'd0,
    A_WDATA  = 3'd1,
    A_CTRL   = 3'd2,
    A_STATUS = 3'd3,
    A_RDATA  = 3'd4,
    A_DRIVE  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic irq_en;
    logic crc_en;
    logic crc_xfer;
    logic mirror_h;
    logic mode_read;
    logic motor_stop;
    logic xfer_run;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{irq_en: 1'b0, crc_en: 1'b0, crc_xfer: 1'b0,
                                 mirror_h: 1'b0, mode_read: 1'b0,
                                 motor_stop: 1'b1, xfer_run: 1'b0};

  function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] d);
    ctrl_t c;
    c.irq_en     = d[7];
    c.crc_en     = d[6];
    c.crc_xfer   = d[4];
    c.mirror_h   = d[3];
    c.mode_read  = d[2];
    c.motor_stop = d[1];
    c.xfer_run   = d[0];
    return c;
  endfunction
endpackage

// File: rtl/disk_xfer_crc.sv
module disk_xfer_crc #(
  parameter int unsigned       CRC_W    = 16,
  parameter logic [CRC_W-1:0]  CRC_POLY = 16'h8408
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic step_i,
  input  logic bit_i,
  output logic crc_bit_o,
  output logic err_o
);
  logic [CRC_W-1:0] crc_q, crc_nxt;
  logic             fb;

  assign fb      = crc_q[0] ^ bit_i;
  assign crc_nxt = (crc_q >> 1) ^ (fb ? CRC_POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (!en_i)  crc_q <= '0;
    else if (step_i) crc_q <= crc_nxt;
  end

  assign crc_bit_o = crc_q[0];
  assign err_o     = |crc_q;

  AST_CRC_CLEARED_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !err_o) else $error("crc not cleared"); // R9
  AST_CRC_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !step_i |=> $stable(crc_q)) else $error("crc moved idle"); // R9
endmodule

// File: rtl/disk_xfer_shift.sv
module disk_xfer_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              mode_read_i,
  input  logic              crc_xfer_i,
  input  logic              crc_bit_i,
  input  logic              bit_en_i,
  input  logic              ser_rd_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flag_clr_i,
  output logic              ser_wr_o,
  output logic              step_o,
  output logic              crc_in_o,
  output logic              byte_rise_o,
  output logic              byte_flag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] out_sr_q, in_sr_q, in_nxt;
  logic              last, tx_bit;

  assign step_o      = bit_en_i & run_i;
  assign last        = (cnt_q == LAST);
  assign byte_rise_o = step_o & last;
  assign in_nxt      = {ser_rd_i, in_sr_q[DATA_W-1:1]};
  assign tx_bit      = crc_xfer_i ? crc_bit_i : out_sr_q[0];
  assign ser_wr_o    = mode_read_i ? 1'b0 : tx_bit;
  assign crc_in_o    = mode_read_i ? ser_rd_i : tx_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (step_o) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  // output register tracks the holding register while idle, reloads per byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_sr_q <= '0;
    else if (!run_i) out_sr_q <= wr_data_i;
    else if (step_o) out_sr_q <= last ? wr_data_i : (out_sr_q >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sr_q   <= '0;
      rd_data_o <= '0;
    end else if (step_o) begin
      in_sr_q <= in_nxt;
      if (last) rd_data_o <= in_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          byte_flag_o <= 1'b0;
    else if (byte_rise_o) byte_flag_o <= 1'b1;
    else if (flag_clr_i)  byte_flag_o <= 1'b0;
  end

  AST_FLAG_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_flag_o) |-> $past(bit_en_i && run_i)) else $error("flag w/o bit"); // R5
  AST_HOLD_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0) else $error("count not held"); // R6
  AST_TX_LSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && !last |=> out_sr_q[DATA_W-2:0] == $past(out_sr_q[DATA_W-1:1]))
    else $error("tx shift order"); // R3
  AST_RD_STABLE_MIDBYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_rise_o |=> $stable(rd_data_o)) else $error("rd data moved"); // R4
endmodule

// File: rtl/disk_xfer_regs.sv
module disk_xfer_regs
  import disk_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              byte_rise_i,
  input  logic              byte_flag_i,
  input  logic              crc_err_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              drv_absent_i,
  input  logic              drv_not_ready_i,
  input  logic              drv_protect_i,
  input  logic              drv_eoh_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              flag_clr_o,
  output logic              irq_o
);
  logic disk_en_q, disk_en_d;
  logic wr_master, wr_wdata, wr_ctrl, rd_status, rd_rdata, irq_ack;
  logic [REG_W-1:0] status_v, drive_v;

  assign wr_master = reg_wr_i && (reg_addr_i == A_MASTER);
  assign wr_wdata  = reg_wr_i && (reg_addr_i == A_WDATA);
  assign wr_ctrl   = reg_wr_i && (reg_addr_i == A_CTRL);
  assign rd_status = reg_rd_i && (reg_addr_i == A_STATUS);
  assign rd_rdata  = reg_rd_i && (reg_addr_i == A_RDATA);

  assign flag_clr_o = wr_wdata | rd_status | rd_rdata;
  assign irq_ack    = flag_clr_o | wr_ctrl;
  assign disk_en_d  = wr_master ? reg_wdata_i[0] : disk_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disk_en_q <= 1'b0;
      ctrl_o    <= CTRL_RST;
      wr_data_o <= '0;
    end else begin
      disk_en_q <= disk_en_d;
      if (wr_ctrl)  ctrl_o    <= decode_ctrl(reg_wdata_i);
      if (wr_wdata) wr_data_o <= reg_wdata_i[DATA_W-1:0];
    end
  end

  // new boundary wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           irq_o <= 1'b0;
    else if (!disk_en_d)                   irq_o <= 1'b0;
    else if (byte_rise_i && ctrl_o.irq_en) irq_o <= 1'b1;
    else if (irq_ack)                      irq_o <= 1'b0;
  end

  assign status_v = {~drv_absent_i & ~drv_not_ready_i, drv_eoh_i, 1'b0, crc_err_i,
                     2'b00, byte_flag_i, 1'b0};
  assign drive_v  = {5'b0, drv_protect_i, drv_not_ready_i, drv_absent_i};

  always_comb begin
    unique case (reg_addr_i)
      A_MASTER: reg_rdata_o = {7'b0, disk_en_q};
      A_WDATA:  reg_rdata_o = REG_W'(wr_data_o);
      A_CTRL:   reg_rdata_o = {ctrl_o.irq_en, ctrl_o.crc_en, 1'b1, ctrl_o.crc_xfer,
                               ctrl_o.mirror_h, ctrl_o.mode_read, ctrl_o.motor_stop,
                               ctrl_o.xfer_run};
      A_STATUS: reg_rdata_o = status_v;
      A_RDATA:  reg_rdata_o = REG_W'(rd_data_i);
      A_DRIVE:  reg_rdata_o = drive_v;
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_NEEDS_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(byte_rise_i)) else $error("irq w/o byte"); // R7
  AST_MASTER_OFF_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disk_en_q |-> !irq_o) else $error("irq while disabled"); // R8
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack && !byte_rise_i |=> !irq_o) else $error("ack ignored"); // R7
endmodule

// File: rtl/disk_xfer_ctrl.sv
module disk_xfer_ctrl
  import disk_xfer_pkg::*;
#(
  parameter int unsigned      DATA_W   = REG_W,
  parameter int unsigned      CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              bit_en_i,
  input  logic              ser_rd_i,
  input  logic              drv_absent_i,
  input  logic              drv_not_ready_i,
  input  logic              drv_protect_i,
  input  logic              drv_eoh_i,
  output logic              ser_wr_o,
  output logic              motor_stop_o,
  output logic              mode_read_o,
  output logic              mirror_h_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic flag_clr, byte_rise, byte_flag, step, crc_in, crc_bit, crc_err, run;

  assign run          = ctrl.xfer_run & ~ctrl.motor_stop;
  assign motor_stop_o = ctrl.motor_stop;
  assign mode_read_o  = ctrl.mode_read;
  assign mirror_h_o   = ctrl.mirror_h;

  disk_xfer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
    .byte_rise_i(byte_rise), .byte_flag_i(byte_flag), .crc_err_i(crc_err),
    .rd_data_i(rd_data), .drv_absent_i, .drv_not_ready_i, .drv_protect_i, .drv_eoh_i,
    .ctrl_o(ctrl), .wr_data_o(wr_data), .flag_clr_o(flag_clr), .irq_o
  );

  disk_xfer_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .run_i(run), .mode_read_i(ctrl.mode_read),
    .crc_xfer_i(ctrl.crc_xfer), .crc_bit_i(crc_bit), .bit_en_i, .ser_rd_i,
    .wr_data_i(wr_data), .flag_clr_i(flag_clr), .ser_wr_o, .step_o(step),
    .crc_in_o(crc_in), .byte_rise_o(byte_rise), .byte_flag_o(byte_flag),
    .rd_data_o(rd_data)
  );

  disk_xfer_crc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk_i, .rst_ni, .en_i(ctrl.crc_en), .step_i(step), .bit_i(crc_in),
    .crc_bit_o(crc_bit), .err_o(crc_err)
  );

  AST_MOTOR_FOLLOWS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == A_CTRL |=> motor_stop_o == $past(reg_wdata_i[1]))
    else $error("motor bit"); // R2
  AST_IDLE_NO_READ_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_read_o |-> !ser_wr_o) else $error("tx in read mode"); // R3
endmodule

// File: tb/disk_xfer_ctrl_tb.sv
module disk_xfer_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       bit_en = 0, ser_rd = 0;
  logic       drv_absent = 0, drv_not_ready = 0, drv_protect = 1, drv_eoh = 1;
  logic       ser_wr, motor_stop, mode_read, mirror_h, irq;

  int n_chk = 0, n_err = 0;
  logic exp_q[$];
  logic mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disk_xfer_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bit_en_i(bit_en), .ser_rd_i(ser_rd), .drv_absent_i(drv_absent),
    .drv_not_ready_i(drv_not_ready), .drv_protect_i(drv_protect), .drv_eoh_i(drv_eoh),
    .ser_wr_o(ser_wr), .motor_stop_o(motor_stop), .mode_read_o(mode_read),
    .mirror_h_o(mirror_h), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each transmitted bit with the queue head
  always @(negedge clk) begin
    #2;
    if (mon_on && bit_en) begin
      if (exp_q.size() == 0) check("R3 tx bit unexpected", 16'(ser_wr), 16'hx);
      else check("R3/R10 tx bit", 16'(ser_wr), 16'(exp_q.pop_front()));
    end
  end

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic f = r[0] ^ b[i];
      r = (r >> 1) ^ (f ? 16'h8408 : 16'h0000);
    end
    return r;
  endfunction

  task automatic push_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic bit_clk(input logic b);
    @(negedge clk); bit_en = 1; ser_rd = b;
    @(negedge clk); bit_en = 0;
  endtask

  task automatic feed(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bit_clk(b[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    check("R1 motor_stop", 16'(motor_stop), 16'd1);
    check("R1 mode", 16'(mode_read), 16'd0);
    check("R1 mirror", 16'(mirror_h), 16'd0);
    check("R1 irq", 16'(irq), 16'd0);
    peek(3'd0, d); check("R1 master", 16'(d), 16'h00);
    // R11
    peek(3'd3, d); check("R1/R11 status", 16'(d), 16'hC0);
    peek(3'd5, d); check("R11 drive", 16'(d), 16'h04);
    drv_eoh = 0; drv_not_ready = 1; drv_protect = 0; drv_absent = 1;
    peek(3'd3, d); check("R11 status not ready", 16'(d), 16'h00);
    peek(3'd5, d); check("R11 drive lines", 16'(d), 16'h03);
    drv_absent = 0; drv_not_ready = 0;
    // R2
    wr(3'd2, 8'h0C);
    check("R2 motor", 16'(motor_stop), 16'd0);
    check("R2 mode", 16'(mode_read), 16'd1);
    check("R2 mirror", 16'(mirror_h), 16'd1);
    // R6: held by transfer reset, then by motor stop
    wr(3'd2, 8'h04); feed(8'hFF);
    peek(3'd3, d); check("R6 flag held xfer", 16'(d[1]), 16'd0);
    wr(3'd2, 8'h07); feed(8'hFF);
    peek(3'd3, d); check("R6 flag held motor", 16'(d[1]), 16'd0);
    // R4 R5 R7 read path
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h85);
    feed(8'hA5);
    peek(3'd3, d); check("R5 flag set", 16'(d[1]), 16'd1);
    check("R7 irq set", 16'(irq), 16'd1);
    peek(3'd4, d); check("R4 rdata", 16'(d), 16'hA5);
    rd(3'd4, d);
    peek(3'd3, d); check("R5 clr by rdata read", 16'(d[1]), 16'd0);
    check("R7 ack by rdata read", 16'(irq), 16'd0);
    feed(8'h3C);
    peek(3'd4, d); check("R4 rdata 2", 16'(d), 16'h3C);
    rd(3'd3, d); check("R5 status shows flag", 16'(d[1]), 16'd1);
    peek(3'd3, d); check("R5 clr by status read", 16'(d[1]), 16'd0);
    check("R7 ack by status read", 16'(irq), 16'd0);
    feed(8'hFF);
    wr(3'd1, 8'h00);
    peek(3'd3, d); check("R5 clr by wdata write", 16'(d[1]), 16'd0);
    check("R7 ack by wdata write", 16'(irq), 16'd0);
    feed(8'h01);
    check("R7 irq again", 16'(irq), 16'd1);
    wr(3'd2, 8'h85);
    check("R7 ack by ctrl write", 16'(irq), 16'd0);
    peek(3'd3, d); check("R5 ctrl write keeps flag", 16'(d[1]), 16'd1);
    wr(3'd2, 8'h05); rd(3'd3, d);
    feed(8'h02);
    check("R7 no irq when disabled", 16'(irq), 16'd0);
    peek(3'd3, d); check("R7 flag without irq", 16'(d[1]), 16'd1);
    // R8
    wr(3'd2, 8'h85); rd(3'd3, d);
    feed(8'h77);
    check("R8 irq before", 16'(irq), 16'd1);
    wr(3'd0, 8'h00);
    check("R8 master off clears", 16'(irq), 16'd0);
    feed(8'h66);
    check("R8 stays off", 16'(irq), 16'd0);
    peek(3'd4, d); check("R8 data still flows", 16'(d), 16'h66);
    wr(3'd0, 8'h01);
    // R9 read-side CRC
    wr(3'd2, 8'h05); wr(3'd2, 8'h45);
    c = crc_upd(crc_upd(16'h0000, 8'h12), 8'h34);
    feed(8'h12); feed(8'h34);
    peek(3'd3, d); check("R9 crc mid", 16'(d[4]), 16'(c != 0));
    feed(c[7:0]); feed(c[15:8]);
    peek(3'd3, d); check("R9 crc good", 16'(d[4]), 16'd0);
    wr(3'd2, 8'h05); wr(3'd2, 8'h45);
    feed(8'h12); feed(8'h34); feed(c[7:0] ^ 8'h01); feed(c[15:8]);
    peek(3'd3, d); check("R9 crc bad", 16'(d[4]), 16'd1);
    wr(3'd2, 8'h05);
    peek(3'd3, d); check("R9 crc reset", 16'(d[4]), 16'd0);
    // R3 R10 write path
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h5A);
    wr(3'd2, 8'h41);
    wr(3'd1, 8'hC3);
    push_byte(8'h5A); push_byte(8'hC3);
    mon_on = 1'b1;
    feed(8'h00); feed(8'h00);
    wr(3'd2, 8'h51);
    c = crc_upd(crc_upd(16'h0000, 8'h5A), 8'hC3);
    push_byte(c[7:0]); push_byte(c[15:8]);
    feed(8'h00); feed(8'h00);
    mon_on = 1'b0;
    check("R3/R10 queue drained", 16'(exp_q.size()), 16'd0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule